// File: doc/BRIEF.md
# Serial Queue Pair with DMA Handshake

This block holds the two byte queues of a serial controller: a transmit queue that the host fills and the transmit shifter drains, and a receive queue that the receive shifter fills and the host drains. Each queue holds 64 bytes when queueing is switched on. When queueing is off, each queue behaves as a single-byte holding register. The block reports how many bytes each queue holds and keeps a sticky overrun flag per queue.

Two active-low handshake outputs, `txrdy_n` and `rxrdy_n`, let an external DMA engine move data in blocks. Both are derived from queue occupancy, a trigger level per direction and the selected DMA mode. Mode 0 gives a per-byte handshake. Mode 1 gives a block handshake with hysteresis between a full or empty limit and the trigger level. A single host control write sets the queue enable, the DMA mode and both trigger selects, and can clear either queue.

Top module: `sq_dma_ctl`

## Requirements
- R1: After reset both levels are 0, both overrun flags are 0, `txrdy_n` is 0, `rxrdy_n` is 1, queueing is off and DMA mode 0 is selected.
- R2: With queueing on, a queue accepts up to 64 bytes and its level never exceeds 64. With queueing off, the capacity of each queue is 1.
- R3: Bytes leave each queue in the order they entered. A popped byte appears on the data output in the cycle after the pop.
- R4: A push to a queue at capacity is discarded without changing its level or contents, and it sets that queue's overrun flag. The flag stays set until that queue is cleared.
- R5: A pop from an empty queue leaves the level at 0 and leaves the data output at the last popped value.
- R6: A control write with bit 2 set clears the transmit queue (level and overrun flag), and one with bit 1 set clears the receive queue, each at that clock edge and without touching the other queue. A control write that changes bit 0 clears both queues.
- R7: Control write fields: bit 0 is the queue enable, bit 3 selects DMA mode 1, bits 5:4 select the transmit trigger (00 gives 16, 01 gives 8, 10 gives 32, 11 gives 56), and bits 7:6 select the receive trigger (00 gives 1, 01 gives 16, 10 gives 32, 11 gives 56).
- R8: In DMA mode 0, or whenever queueing is off, `txrdy_n` is 0 exactly when the transmit level is 0.
- R9: In DMA mode 1 with queueing on, `txrdy_n` rises when the transmit queue becomes full. It stays 1 while the level is above the transmit trigger, then falls and stays 0 until the queue is full again.
- R10: In DMA mode 0, or whenever queueing is off, `rxrdy_n` is 0 exactly when the receive level is non-zero.
- R11: In DMA mode 1 with queueing on, `rxrdy_n` falls when the receive level reaches the receive trigger. It stays 0 until the level returns to 0, then stays 1 until the trigger is reached again.
- R12: A push and a pop in the same cycle on a full queue are both accepted, and the level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (fields per R7, clears per R6) |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_din | input | 8 | Transmit byte from the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_dout | output | 8 | Byte handed to the transmit shifter |
| tx_level | output | 7 | Transmit queue occupancy |
| tx_ovr | output | 1 | Sticky transmit overrun flag |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_dout | output | 8 | Received byte returned to the host |
| rx_level | output | 7 | Receive queue occupancy |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |

## Verification
The hardest situation to reach is the mode-1 hysteresis band. The occupancy lies between the trigger and the limit, and the handshake value depends on which limit was crossed last. The stimulus fills the transmit queue to 64, drains it one byte at a time past the trigger, and refills it only partly. It does the same on the receive side, draining to one byte and then to zero. It also swaps a byte in and out while the queue is full, and moves the trigger select while the queue sits inside the band.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma1;
    logic       on;
  } sq_cfg_t;

  // transmit trigger as a fraction of the depth; select 00 is the reset value
  function automatic int tx_trig_of(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 8;
      2'd2:    return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

  function automatic int rx_trig_of(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

  function automatic logic block_mode(input sq_cfg_t c);
    return c.on & c.dma1;
  endfunction

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output sq_cfg_t    cfg,
  output logic       clr_tx,
  output logic       clr_rx
);

  logic on_flip;

  assign on_flip = cfg_we & (cfg_wdata[0] != cfg.on);
  assign clr_tx  = on_flip | (cfg_we & cfg_wdata[2]);
  assign clr_rx  = on_flip | (cfg_we & cfg_wdata[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we) begin
      cfg.on     <= cfg_wdata[0];
      cfg.dma1   <= cfg_wdata[3];
      cfg.tx_sel <= cfg_wdata[5:4];
      cfg.rx_sel <= cfg_wdata[7:6];
    end
  end

endmodule

// File: rtl/sq_byte_queue.sv
module sq_byte_queue #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_one,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          ovr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cap;
  logic          room;

  assign cap     = cap_one ? LW'(1) : FULL_LVL;
  assign pop_ok  = pop & ~clr & (level != '0);
  assign room    = (level < cap) | pop_ok;
  assign push_ok = push & ~clr & room;
  assign drop    = push & ~clr & ~room;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
      dout   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= ptr_inc(rd_ptr);
        dout   <= mem[rd_ptr];
      end
      level <= level + LW'(push_ok) - LW'(pop_ok);
      if (drop) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/sq_ready.sv
module sq_ready #(
  parameter int DEPTH = 64,
  parameter bit IS_TX = 1'b1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode1,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig,
  output logic          rdy_n
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic flag_q, flag_d;

  generate
    if (IS_TX) begin : g_tx
      // held high from full until occupancy drops to the trigger
      assign flag_d = (level == FULL_LVL) | (flag_q & (level > trig));
      assign rdy_n  = mode1 ? flag_d : (level != '0);
    end else begin : g_rx
      // active from the trigger until the queue empties
      assign flag_d = (level >= trig) | (flag_q & (level != '0));
      assign rdy_n  = mode1 ? ~flag_d : (level == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/sq_dma_ctl.sv
module sq_dma_ctl
  import sq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [LW-1:0] tx_level,
  output logic          tx_ovr,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [LW-1:0] rx_level,
  output logic          rx_ovr,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  sq_cfg_t       cfg;
  logic          clr_tx, clr_rx;
  logic          mode1;
  logic [LW-1:0] tx_trig, rx_trig;
  logic          tx_push_ok, tx_pop_ok, tx_drop;
  logic          rx_push_ok, rx_pop_ok, rx_drop;

  assign mode1   = block_mode(cfg);
  assign tx_trig = LW'(tx_trig_of(cfg.tx_sel, DEPTH));
  assign rx_trig = LW'(rx_trig_of(cfg.rx_sel, DEPTH));

  sq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg(cfg), .clr_tx(clr_tx), .clr_rx(clr_rx)
  );

  sq_byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_tx), .cap_one(~cfg.on),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .level(tx_level), .ovr(tx_ovr),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .drop(tx_drop)
  );

  sq_byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .cap_one(~cfg.on),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .level(rx_level), .ovr(rx_ovr),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .drop(rx_drop)
  );

  sq_ready #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txrdy (
    .clk(clk), .rst_n(rst_n), .mode1(mode1),
    .level(tx_level), .trig(tx_trig), .rdy_n(txrdy_n)
  );

  sq_ready #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxrdy (
    .clk(clk), .rst_n(rst_n), .mode1(mode1),
    .level(rx_level), .trig(rx_trig), .rdy_n(rxrdy_n)
  );

endmodule

// File: rtl/sq_dma_chk.sv
module sq_dma_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode1,
  input logic          clr_tx,
  input logic          clr_rx,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          tx_drop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_drop,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_trig,
  input logic [DW-1:0] rx_dout,
  input logic          tx_ovr,
  input logic          rx_ovr,
  input logic          txrdy_n,
  input logic          rxrdy_n
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL_LVL) && (rx_level <= FULL_LVL));

  p_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> (tx_ovr && $stable(tx_level)));

  p_rx_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> (rx_ovr && $stable(rx_level)));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && !clr_rx && rx_level == '0) |=> ($stable(rx_dout) && rx_level == '0));

  p_clear_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx |=> (tx_level == '0 && !tx_ovr));

  p_clear_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx |=> (rx_level == '0 && !rx_ovr));

  p_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode1 && tx_level == '0) |-> !txrdy_n);

  p_tx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && tx_level == FULL_LVL) |-> txrdy_n);

  p_tx_band_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && txrdy_n) |=> (!mode1 || tx_level <= tx_trig || txrdy_n));

  p_rx_avail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode1 && rx_level != '0) |-> !rxrdy_n);

  p_rx_band_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rxrdy_n) |=> (!mode1 || rx_level == '0 || !rxrdy_n));

  p_full_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && tx_level == FULL_LVL && tx_push && tx_pop && !clr_tx) |=> (tx_level == FULL_LVL));

endmodule

bind sq_dma_ctl sq_dma_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode1(mode1), .clr_tx(clr_tx), .clr_rx(clr_rx),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_drop(tx_drop),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_drop(rx_drop),
  .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig),
  .rx_dout(rx_dout), .tx_ovr(tx_ovr), .rx_ovr(rx_ovr),
  .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
);

// File: tb/sq_dma_ctl_tb.sv
module sq_dma_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_din = '0, rx_din = '0;
  logic [7:0] tx_dout, rx_dout;
  logic [6:0] tx_level, rx_level;
  logic       tx_ovr, rx_ovr, txrdy_n, rxrdy_n;

  int n_chk = 0;
  int n_bad = 0;
  int tcap = 1;
  int rcap = 1;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  always #5 clk = ~clk;

  sq_dma_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_level(tx_level), .tx_ovr(tx_ovr),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_level(rx_level), .rx_ovr(rx_ovr),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitors: compare popped bytes against the scoreboard (R3)
  always @(posedge clk) begin
    if (rst_n && tx_pop && tx_level != 0) begin
      #1;
      if (tx_exp.size() > 0) chk("R3 tx order", {24'd0, tx_dout}, {24'd0, tx_exp.pop_front()});
    end
  end

  always @(posedge clk) begin
    if (rst_n && rx_pop && rx_level != 0) begin
      #1;
      if (rx_exp.size() > 0) chk("R3 rx order", {24'd0, rx_dout}, {24'd0, rx_exp.pop_front()});
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_push = 1'b1; tx_din = b;
    if (tx_exp.size() < tcap) tx_exp.push_back(b);
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_din = b;
    if (rx_exp.size() < rcap) rx_exp.push_back(b);
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 ovr", {tx_ovr, rx_ovr}, 0);
    chk("R1 txrdy_n", txrdy_n, 0);
    chk("R1 rxrdy_n", rxrdy_n, 1);

    // queueing on, DMA mode 0
    wr_cfg(8'h01); tcap = 64; rcap = 64;
    push_tx(8'hA1);
    chk("R8 txrdy_n busy", txrdy_n, 1);
    push_tx(8'hA2); push_tx(8'hA3);
    chk("R2 tx_level 3", tx_level, 3);
    for (int i = 0; i < 3; i++) pop_tx();
    chk("R8 txrdy_n empty", txrdy_n, 0);
    push_rx(8'h5C);
    chk("R10 rxrdy_n avail", rxrdy_n, 0);
    pop_rx();
    chk("R10 rxrdy_n empty", rxrdy_n, 1);

    // fill, overflow, drain, empty pop
    for (int i = 0; i < 64; i++) push_tx(8'(i * 7 + 3));
    chk("R2 tx full level", tx_level, 64);
    chk("R4 ovr clear before", tx_ovr, 0);
    push_tx(8'hEE);
    chk("R4 level after drop", tx_level, 64);
    chk("R4 ovr set", tx_ovr, 1);
    for (int i = 0; i < 64; i++) pop_tx();
    last = tx_dout;
    chk("R4 dropped byte absent", {24'd0, last}, {24'd0, 8'(63 * 7 + 3)});
    pop_tx();
    chk("R5 level stays 0", tx_level, 0);
    chk("R5 dout unchanged", {24'd0, tx_dout}, {24'd0, last});
    chk("R4 ovr sticky", tx_ovr, 1);

    // per-queue clears
    for (int i = 0; i < 5; i++) begin push_tx(8'(i + 16)); push_rx(8'(i + 32)); end
    wr_cfg(8'h05); tx_exp.delete();
    chk("R6 tx cleared", tx_level, 0);
    chk("R6 tx ovr cleared", tx_ovr, 0);
    chk("R6 rx untouched", rx_level, 5);
    wr_cfg(8'h03); rx_exp.delete();
    chk("R6 rx cleared", rx_level, 0);

    // DMA mode 1, transmit trigger 16
    wr_cfg(8'h09);
    for (int i = 0; i < 63; i++) push_tx(8'(i + 100));
    chk("R9 below full low", txrdy_n, 0);
    push_tx(8'h77);
    chk("R9 full high", txrdy_n, 1);
    @(negedge clk);
    tx_push = 1'b1; tx_pop = 1'b1; tx_din = 8'h99; tx_exp.push_back(8'h99);
    @(negedge clk);
    tx_push = 1'b0; tx_pop = 1'b0;
    chk("R12 swap keeps full", tx_level, 64);
    chk("R12 txrdy_n high", txrdy_n, 1);
    for (int i = 0; i < 47; i++) pop_tx();
    chk("R9 band level", tx_level, 17);
    chk("R9 band high", txrdy_n, 1);
    pop_tx();
    chk("R9 at trigger low", txrdy_n, 0);
    push_tx(8'h42);
    chk("R9 refill stays low", txrdy_n, 0);
    wr_cfg(8'h29);
    for (int i = 0; i < 47; i++) push_tx(8'(i + 200));
    chk("R7 full again high", txrdy_n, 1);
    for (int i = 0; i < 31; i++) pop_tx();
    chk("R7 trig32 band high", txrdy_n, 1);
    pop_tx();
    chk("R7 trig32 low", txrdy_n, 0);
    wr_cfg(8'h2D); tx_exp.delete();
    chk("R6 tx clear mode1", tx_level, 0);

    // DMA mode 1, receive trigger 16
    wr_cfg(8'h49);
    for (int i = 0; i < 15; i++) push_rx(8'(i + 50));
    chk("R11 below trigger high", rxrdy_n, 1);
    push_rx(8'h80);
    chk("R11 trigger low", rxrdy_n, 0);
    for (int i = 0; i < 15; i++) pop_rx();
    chk("R11 one left low", rxrdy_n, 0);
    pop_rx();
    chk("R11 empty high", rxrdy_n, 1);
    for (int i = 0; i < 15; i++) push_rx(8'(i + 70));
    chk("R11 refill below trigger", rxrdy_n, 1);
    wr_cfg(8'h09);
    chk("R7 rx trig1 low", rxrdy_n, 0);
    for (int i = 0; i < 15; i++) pop_rx();

    // queueing off: single-byte holding registers
    push_tx(8'h11); push_rx(8'h22);
    wr_cfg(8'h00); tx_exp.delete(); rx_exp.delete(); tcap = 1; rcap = 1;
    chk("R6 enable flip clears tx", tx_level, 0);
    chk("R6 enable flip clears rx", rx_level, 0);
    push_tx(8'hB1);
    push_tx(8'hB2);
    chk("R2 capacity one", tx_level, 1);
    chk("R4 ovr disabled", tx_ovr, 1);
    wr_cfg(8'h08);
    chk("R8 disabled ignores dma", txrdy_n, 1);
    pop_tx();
    chk("R3 single byte", {24'd0, tx_dout}, {24'd0, 8'hB1});
    chk("R8 disabled empty", txrdy_n, 0);
    push_rx(8'hC3);
    chk("R10 disabled rx avail", rxrdy_n, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule